// File: doc/BRIEF.md
# Reconfigurable Cluster Barrier Synchronizer

This block gives sixteen processing elements a hardware barrier whose groups can be redrawn at run time. Software assigns each element a 4-bit group number through a small write port. Elements that share a number form one group, so the group count and the group sizes follow from whatever partition software picks. When an element finishes its share of a statically scheduled basic block, it raises its arrive line and holds it. Once every member of its group holds arrive, the block pulses a go line to all of those members in the same cycle.

Groups work on their own. Arrivals in one group never hold up or trigger another group. Each element also has a phase bit that flips on every go it receives. Software can compare the phase bit with its own count to tell one barrier episode from the next, even when barriers come back to back. The group table may only change while the unit is idle. A write made while any barrier is in flight is dropped, and an error pulse reports it.

Top module: `cluster_barrier`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, pe_go, pe_phase and cfg_err are all zero. Reset places every element in group 0, so the first barrier after reset spans all sixteen elements.
- R2: When the last member of a group is sampled with pe_arrive high at clock edge T, pe_go goes high for every member of that group after edge T+2 and for no element outside it.
- R3: pe_go stays low for a group while any of its members has pe_arrive low.
- R4: Groups are independent. A group whose members have all arrived is released on time, whatever the members of other groups are doing.
- R5: An element that is the only member of its group is released two edges after its arrive is first sampled.
- R6: pe_go is a single-cycle pulse. An element that keeps pe_arrive high after its go is not released again until it drops arrive and raises it again.
- R7: Bit i of pe_phase flips in exactly the cycle in which bit i of pe_go is high, and holds its value otherwise.
- R8: A write with cfg_we high stores cfg_group as the group of element cfg_pe, provided no barrier is pending. A barrier is pending while any pe_arrive is high or any arrival is still being processed. The new grouping governs the next barrier, and cfg_err stays low.
- R9: A write made while a barrier is pending leaves the table unchanged. It raises cfg_err for exactly the one cycle after the rejecting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Group table write strobe |
| cfg_pe | input | 4 | Element whose group entry is written |
| cfg_group | input | 4 | Group number to store |
| cfg_err | output | 1 | One-cycle pulse: a write was rejected because a barrier was pending |
| pe_arrive | input | 16 | Per-element arrive level, held until go is seen |
| pe_go | output | 16 | Per-element release pulse |
| pe_phase | output | 16 | Per-element phase bit, flipped on each release |

## Verification
The hardest case to reach from the ports is a rejected table write whose effect would change membership. Since cfg_err is the only visible sign of the rejection, the bench also has to show that the table really stayed the same. The stimulus parks six members of group 0 at the barrier, tries to move one of them into an empty group, and then completes group 0. If the write had taken effect, the moved element would have been released early as a lone member, and group 0 would have been released without it. The scoreboard flags either outcome. Immediate back-to-back barriers on one group test whether a held arrive gets counted twice.

// File: rtl/cb_pkg.sv
// Package: shared sizing for the cluster barrier block.
// Assumes: the element count fits the index width derived at the top.
package cb_pkg;
    parameter int unsigned CB_NUM_PE = 16;
    parameter int unsigned CB_GRP_W  = 4;
endpackage

// File: rtl/cb_group_table.sv
// Module: group membership table with guarded writes.
// Holds one group number per element. A write is accepted only when
// the busy input is low; otherwise it is dropped and err pulses for
// one cycle. Assumes busy reflects every barrier stage downstream.
module cb_group_table #(
    parameter int unsigned NUM_PE = 16,
    parameter int unsigned GRP_W  = 4,
    parameter int unsigned IDX_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [GRP_W-1:0]          wr_grp,
    input  logic                      busy,
    output logic [NUM_PE*GRP_W-1:0]   grp_flat,
    output logic                      err
);
    logic [GRP_W-1:0] tbl [NUM_PE];

    // Table storage and rejected-write flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PE; i++) tbl[i] <= '0;
            err <= 1'b0;
        end else begin
            err <= wr_en & busy;
            if (wr_en && !busy && (int'(wr_idx) < NUM_PE))
                tbl[wr_idx] <= wr_grp;
        end
    end

    // Flatten the table for the downstream stages.
    for (genvar g = 0; g < NUM_PE; g++) begin : g_flat
        assign grp_flat[g*GRP_W +: GRP_W] = tbl[g];
    end
endmodule

// File: rtl/cb_arrive_track.sv
// Module: per-element arrival capture.
// Registers the arrive levels and masks out elements already served
// in the current episode, so a held arrive counts once. Assumes an
// element keeps arrive high until it has seen its go pulse.
module cb_arrive_track #(
    parameter int unsigned NUM_PE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PE-1:0] arrive,
    input  logic [NUM_PE-1:0] fire_pe,
    output logic [NUM_PE-1:0] arr_q,
    output logic [NUM_PE-1:0] live
);
    logic [NUM_PE-1:0] served;

    // Sample arrivals and remember served elements until arrive drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_q  <= '0;
            served <= '0;
        end else begin
            arr_q  <= arrive;
            served <= arrive & (served | fire_pe);
        end
    end

    // Arrivals that still count toward a barrier.
    assign live = arr_q & ~served;
endmodule

// File: rtl/cb_group_detect.sv
// Module: per-group completion detection.
// For every possible group number, completion means the group has at
// least one member and every member has a live arrival. The result is
// registered once; a per-element fire vector feeds back to the tracker.
module cb_group_detect #(
    parameter int unsigned NUM_PE = 16,
    parameter int unsigned GRP_W  = 4,
    parameter int unsigned NUM_GRP = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_PE*GRP_W-1:0] grp_flat,
    input  logic [NUM_PE-1:0]       live,
    output logic [NUM_PE-1:0]       fire_pe,
    output logic [NUM_GRP-1:0]      done_q
);
    logic [NUM_GRP-1:0] done_now;

    for (genvar c = 0; c < NUM_GRP; c++) begin : g_grp
        logic [NUM_PE-1:0] member;
        // Membership mask and completion for group c.
        always_comb begin
            for (int i = 0; i < NUM_PE; i++)
                member[i] = (grp_flat[i*GRP_W +: GRP_W] == GRP_W'(c));
            done_now[c] = (|member) & (&(live | ~member));
        end
    end

    // Route each group's completion back to its own members.
    for (genvar p = 0; p < NUM_PE; p++) begin : g_fire
        assign fire_pe[p] = done_now[grp_flat[p*GRP_W +: GRP_W]];
    end

    // Register completion: second stage of the release pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= '0;
        else        done_q <= done_now;
    end
endmodule

// File: rtl/cb_release.sv
// Module: release fan-out and phase bits.
// Expands registered group completion into per-element go pulses and
// flips each element's phase bit on its go. Assumes the table is
// stable while done_q is nonzero.
module cb_release #(
    parameter int unsigned NUM_PE = 16,
    parameter int unsigned GRP_W  = 4,
    parameter int unsigned NUM_GRP = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_PE*GRP_W-1:0] grp_flat,
    input  logic [NUM_GRP-1:0]      done_q,
    output logic [NUM_PE-1:0]       go,
    output logic [NUM_PE-1:0]       phase
);
    logic [NUM_PE-1:0] go_next;

    for (genvar p = 0; p < NUM_PE; p++) begin : g_fan
        assign go_next[p] = done_q[grp_flat[p*GRP_W +: GRP_W]];
    end

    // Register go pulses and toggle phase bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go    <= '0;
            phase <= '0;
        end else begin
            go    <= go_next;
            phase <= phase ^ go_next;
        end
    end
endmodule

// File: rtl/cluster_barrier.sv
// Module: reconfigurable cluster barrier (top).
// Sixteen elements, software-assigned to groups by number. A group is
// released two edges after its last arrival is sampled. Assumes each
// element holds arrive until it sees go.
module cluster_barrier
    import cb_pkg::*;
#(
    parameter int unsigned NUM_PE = CB_NUM_PE,
    parameter int unsigned GRP_W  = CB_GRP_W,
    localparam int unsigned IDX_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
    localparam int unsigned NUM_GRP = 1 << GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_pe,
    input  logic [GRP_W-1:0]  cfg_group,
    output logic              cfg_err,
    input  logic [NUM_PE-1:0] pe_arrive,
    output logic [NUM_PE-1:0] pe_go,
    output logic [NUM_PE-1:0] pe_phase
);
    logic [NUM_PE*GRP_W-1:0] grp_flat;
    logic [NUM_PE-1:0]       arr_q;
    logic [NUM_PE-1:0]       live;
    logic [NUM_PE-1:0]       fire_pe;
    logic [NUM_GRP-1:0]      done_q;
    logic                    busy;

    // A barrier is pending while any stage holds an arrival.
    assign busy = (|pe_arrive) | (|arr_q) | (|done_q);

    cb_group_table #(.NUM_PE(NUM_PE), .GRP_W(GRP_W), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_pe),
        .wr_grp(cfg_group), .busy(busy), .grp_flat(grp_flat), .err(cfg_err)
    );

    cb_arrive_track #(.NUM_PE(NUM_PE)) u_track (
        .clk(clk), .rst_n(rst_n), .arrive(pe_arrive), .fire_pe(fire_pe),
        .arr_q(arr_q), .live(live)
    );

    cb_group_detect #(.NUM_PE(NUM_PE), .GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_detect (
        .clk(clk), .rst_n(rst_n), .grp_flat(grp_flat), .live(live),
        .fire_pe(fire_pe), .done_q(done_q)
    );

    cb_release #(.NUM_PE(NUM_PE), .GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_rel (
        .clk(clk), .rst_n(rst_n), .grp_flat(grp_flat), .done_q(done_q),
        .go(pe_go), .phase(pe_phase)
    );
endmodule

// File: rtl/cluster_barrier_chk.sv
// Module: property checker for the cluster barrier, bound to the top.
module cluster_barrier_chk #(
    parameter int unsigned NUM_PE = 16,
    parameter int unsigned GRP_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we,
    input logic                    cfg_err,
    input logic [NUM_PE-1:0]       pe_arrive,
    input logic [NUM_PE-1:0]       pe_go,
    input logic [NUM_PE-1:0]       pe_phase,
    input logic [NUM_PE*GRP_W-1:0] grp_flat
);
    // True when every element sharing a group with a released one is released too.
    function automatic logic whole_group(logic [NUM_PE-1:0] r, logic [NUM_PE*GRP_W-1:0] t);
        for (int i = 0; i < NUM_PE; i++)
            for (int j = 0; j < NUM_PE; j++)
                if (r[i] && !r[j] && t[i*GRP_W +: GRP_W] == t[j*GRP_W +: GRP_W])
                    return 1'b0;
        return 1'b1;
    endfunction

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (pe_go == '0 && pe_phase == '0 && !cfg_err));

    // R2
    whole_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_go != '0) |-> whole_group(pe_go, grp_flat));

    // R3
    arrived_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_go != '0) |-> ((pe_go & ~$past(pe_arrive, 2)) == '0));

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_go != '0) |=> ((pe_go & $past(pe_go)) == '0));

    // R7
    phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pe_phase == ($past(pe_phase) ^ pe_go)));

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_we));
endmodule

bind cluster_barrier cluster_barrier_chk #(.NUM_PE(NUM_PE), .GRP_W(GRP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_err(cfg_err),
    .pe_arrive(pe_arrive), .pe_go(pe_go), .pe_phase(pe_phase), .grp_flat(grp_flat)
);

// File: tb/cluster_barrier_test.sv
module cluster_barrier_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_pe = '0;
    logic [3:0]  cfg_group = '0;
    logic        cfg_err;
    logic [15:0] pe_arrive = '0;
    logic [15:0] pe_go;
    logic [15:0] pe_phase;

    always #2 clk = ~clk;

    cluster_barrier uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pe(cfg_pe),
        .cfg_group(cfg_group), .cfg_err(cfg_err), .pe_arrive(pe_arrive),
        .pe_go(pe_go), .pe_phase(pe_phase)
    );

    typedef struct {
        int          at;
        logic [15:0] m;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          cyc = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          mon_on = 1'b0;
    bit          ended = 1'b0;
    logic [15:0] phase_m = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Monitor: pops expected releases and compares every cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                logic [15:0] m;
                string tag;
                m = '0;
                tag = "R3 R6 idle";
                while (q.size() > 0 && q[0].at == cyc) begin
                    exp_t e;
                    e = q.pop_front();
                    m |= e.m;
                    tag = e.tag;
                end
                phase_m ^= m;
                check16({tag, " go"}, pe_go, m);
                check16("R7 phase", pe_phase, phase_m);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: raise arrivals; queue the release expected three negedges on.
    task automatic raise(logic [15:0] m, logic [15:0] expect_go, string tag);
        pe_arrive = pe_arrive | m;
        if (expect_go != '0) q.push_back('{cyc + 3, expect_go, tag});
    endtask

    task automatic drop(logic [15:0] m);
        pe_arrive = pe_arrive & ~m;
    endtask

    task automatic cfg(int idx, int grp, logic exp_err, string tag);
        cfg_pe = 4'(idx);
        cfg_group = 4'(grp);
        cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
        check16({tag, " err"}, 16'(cfg_err), 16'(exp_err));
        tick(1);
        check16({tag, " err pulse"}, 16'(cfg_err), 16'h0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(2);
        // R1: quiet outputs during reset
        check16("R1 go", pe_go, 16'h0);
        check16("R1 phase", pe_phase, 16'h0);
        check16("R1 err", 16'(cfg_err), 16'h0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        tick(2);

        // R1, R2, R3: default single group of all sixteen
        raise(16'h7FFF, 16'h0, "");
        tick(5);
        raise(16'h8000, 16'hFFFF, "R2 R1");
        tick(3);
        // R6: hold arrive, no second release
        tick(3);
        drop(16'hFFFF);
        tick(3);

        // R8: regroup while idle
        for (int i = 0; i < 4; i++) cfg(i, 1, 1'b0, "R8");
        for (int i = 4; i < 8; i++) cfg(i, 2, 1'b0, "R8");
        cfg(8, 3, 1'b0, "R8");

        // R4: group 1 completes while group 2 is partial
        raise(16'h000F, 16'h000F, "R4");
        raise(16'h0030, 16'h0, "");
        tick(3);
        drop(16'h000F);
        tick(1);
        // R5: lone member
        raise(16'h0100, 16'h0100, "R5");
        tick(3);
        drop(16'h0100);
        raise(16'h00C0, 16'h00F0, "R4");
        tick(3);
        drop(16'h00F0);
        tick(3);

        // R9: write while group 0 is pending is dropped
        raise(16'h7E00, 16'h0, "");
        tick(1);
        cfg(9, 5, 1'b1, "R9");
        raise(16'h8000, 16'hFE00, "R9");
        tick(3);
        drop(16'hFE00);
        tick(3);

        // R7: back-to-back barriers on group 1
        for (int r = 0; r < 3; r++) begin
            raise(16'h000F, 16'h000F, "R7");
            tick(3);
            drop(16'h000F);
            tick(1);
        end
        tick(2);

        // R8: move element 3 into element 8's group
        cfg(3, 3, 1'b0, "R8");
        raise(16'h0007, 16'h0007, "R8");
        raise(16'h0008, 16'h0, "");
        tick(3);
        drop(16'h0007);
        tick(1);
        raise(16'h0100, 16'h0108, "R8");
        tick(3);
        drop(16'h0108);
        tick(4);

        finish_run();
    end
endmodule